// File: doc/BRIEF.md
# VGA indexed register port interface

This block is the register side of a legacy VGA adapter as seen from a byte-wide I/O port bus. It decodes the classic colour-mode VGA port window and holds four indexed register banks: attribute, sequencer, graphics controller and CRT controller. It also holds the miscellaneous output and feature control registers and answers the two input status reads. Video timing and the palette DAC live elsewhere. This block only stores the programmed values and reports the retrace and display-enable levels it is given.

The sequencer, graphics and CRT banks each use a pair of ports: one holds an index, and the other reads or writes the register that index selects. The attribute bank uses a single write port for both index and data. A one-bit phase flag decides whether the next write to that port is an index or a data value. Software puts that flag into a known state by reading input status 1.

The bus is synchronous. An access is one cycle with a read or a write strobe. Read data is registered and appears on the clock edge that ends the strobe cycle.

Top module: `vga_port_regs`

## Requirements
- R1: After reset, every bank register, index latch, the miscellaneous output and feature control registers and the read data output are 0, and the attribute phase is "index".
- R2: A read strobe in one cycle loads io_rdata at the closing clock edge. io_rdata keeps its value in every cycle without a read strobe.
- R3: Port 0x3C4 writes and reads back the sequencer index. Port 0x3C5 writes or reads sequencer register 0..4 selected by that index.
- R4: Port 0x3CE writes and reads back the graphics index. Port 0x3CF writes or reads graphics register 0..8 selected by that index.
- R5: Port 0x3D4 writes and reads back the CRT index. Port 0x3D5 writes or reads CRT register 0..24 selected by that index.
- R6: When a bank's index is at or above its register count, a data write changes nothing and a data read returns 0xFF.
- R7: Writes to 0x3C0 alternate between index and data, starting with index after the phase is cleared. There are 21 attribute registers (0..20). A read of 0x3C0 returns the attribute index, and a read of 0x3C1 returns the selected attribute register.
- R8: Any read of 0x3DA returns the attribute phase to "index", effective for the next cycle's write.
- R9: A read of 0x3DA returns vretrace in bit 3 and the inverse of disp_en in bit 0, with all other bits 0. Both inputs are sampled in the strobe cycle.
- R10: A write to 0x3C2 loads the miscellaneous output register, which reads back at 0x3CC. A read of 0x3C2 returns input status 0, which is 0x00.
- R11: A write to 0x3DA loads the feature control register, which reads back at 0x3CA.
- R12: A read of any port not listed above returns 0xFF. A write to such a port changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| io_addr | input | 16 | Port address |
| io_wr | input | 1 | Write strobe |
| io_rd | input | 1 | Read strobe |
| io_wdata | input | 8 | Write data |
| io_rdata | output | 8 | Registered read data |
| vretrace | input | 1 | Vertical retrace level |
| disp_en | input | 1 | Display enable level |

## Verification
The hardest state to reach is an attribute phase that is half-way through a pair when a status read arrives. From the ports, the phase can only be seen indirectly, through which register the following writes land in. The stimulus therefore writes one index to 0x3C0 and then reads 0x3DA before the matching data write. It then writes an index and data pair and reads back both the attribute index and the selected register. If the phase was not cleared, the index would have been stored as data and the readback would differ. Out-of-range indices are reached by sweeping each bank's index one past its last register.

// File: rtl/vga_port_pkg.sv
package vga_port_pkg;
  localparam int DW = 8;
  localparam int AW = 16;

  localparam int SEQ_REGS  = 5;
  localparam int GFX_REGS  = 9;
  localparam int CRT_REGS  = 25;
  localparam int ATTR_REGS = 21;

  localparam logic [AW-1:0] P_ATTR_WR   = 16'h03C0;
  localparam logic [AW-1:0] P_ATTR_RD   = 16'h03C1;
  localparam logic [AW-1:0] P_MISC_WR   = 16'h03C2;
  localparam logic [AW-1:0] P_SEQ_IDX   = 16'h03C4;
  localparam logic [AW-1:0] P_SEQ_DAT   = 16'h03C5;
  localparam logic [AW-1:0] P_FEAT_RD   = 16'h03CA;
  localparam logic [AW-1:0] P_MISC_RD   = 16'h03CC;
  localparam logic [AW-1:0] P_GFX_IDX   = 16'h03CE;
  localparam logic [AW-1:0] P_GFX_DAT   = 16'h03CF;
  localparam logic [AW-1:0] P_CRT_IDX   = 16'h03D4;
  localparam logic [AW-1:0] P_CRT_DAT   = 16'h03D5;
  localparam logic [AW-1:0] P_STAT1     = 16'h03DA;

  localparam logic [DW-1:0] UNMAPPED_VAL = 8'hFF;
  localparam logic [DW-1:0] STAT0_VAL    = 8'h00;

  localparam int STAT1_VR_BIT = 3;
  localparam int STAT1_DE_BIT = 0;

  typedef enum logic { PH_INDEX = 1'b0, PH_DATA = 1'b1 } attr_phase_e;
endpackage

// File: rtl/vga_idx_bank.sv
module vga_idx_bank #(
  parameter int NUM_REGS = 5,
  parameter int W        = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         idx_we,
  input  logic         dat_we,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] idx_q,
  output logic [W-1:0] dat_rd
);
  logic [W-1:0] idx_d;
  logic         idx_en;
  logic [W-1:0] regs_q [NUM_REGS];

  always_comb begin
    idx_en = idx_we;
    idx_d  = wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      idx_q <= '0;
    else if (idx_en) idx_q <= idx_d;
  end

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    logic reg_en;
    always_comb reg_en = dat_we && (idx_q == W'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      regs_q[g] <= '0;
      else if (reg_en) regs_q[g] <= wdata;
    end
  end

  always_comb begin
    dat_rd = '1;
    for (int i = 0; i < NUM_REGS; i++) begin
      if (idx_q == W'(i)) dat_rd = regs_q[i];
    end
  end
endmodule

// File: rtl/vga_attr_phase.sv
module vga_attr_phase
  import vga_port_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic        port_wr,
  input  logic        clr,
  output attr_phase_e phase_q
);
  attr_phase_e phase_d;

  always_comb begin
    phase_d = phase_q;
    if (clr)          phase_d = PH_INDEX;
    else if (port_wr) phase_d = (phase_q == PH_INDEX) ? PH_DATA : PH_INDEX;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_INDEX;
    else        phase_q <= phase_d;
  end
endmodule

// File: rtl/vga_ctrl_regs.sv
module vga_ctrl_regs
  import vga_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic          misc_we,
  input  logic          feat_we,
  input  logic [DW-1:0] wdata,
  input  logic          vretrace,
  input  logic          disp_en,
  output logic [DW-1:0] misc_q,
  output logic [DW-1:0] feat_q,
  output logic [DW-1:0] stat1
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       misc_q <= '0;
    else if (misc_we) misc_q <= wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       feat_q <= '0;
    else if (feat_we) feat_q <= wdata;
  end

  always_comb begin
    stat1               = '0;
    stat1[STAT1_VR_BIT] = vretrace;
    stat1[STAT1_DE_BIT] = ~disp_en;
  end
endmodule

// File: rtl/vga_port_regs.sv
module vga_port_regs
  import vga_port_pkg::*;
(
  input  logic          clk,
  input  logic          rst_n,
  input  logic [15:0]   io_addr,
  input  logic          io_wr,
  input  logic          io_rd,
  input  logic [7:0]    io_wdata,
  output logic [7:0]    io_rdata,
  input  logic          vretrace,
  input  logic          disp_en
);
  logic [1:0] rst_sync_q;
  logic       rst_int_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_int_n = rst_sync_q[1];

  // address decode
  logic hit_attr_wr, hit_attr_rd, hit_misc_wr, hit_seq_idx, hit_seq_dat;
  logic hit_feat_rd, hit_misc_rd, hit_gfx_idx, hit_gfx_dat;
  logic hit_crt_idx, hit_crt_dat, hit_stat1;

  always_comb begin
    hit_attr_wr = (io_addr == P_ATTR_WR);
    hit_attr_rd = (io_addr == P_ATTR_RD);
    hit_misc_wr = (io_addr == P_MISC_WR);
    hit_seq_idx = (io_addr == P_SEQ_IDX);
    hit_seq_dat = (io_addr == P_SEQ_DAT);
    hit_feat_rd = (io_addr == P_FEAT_RD);
    hit_misc_rd = (io_addr == P_MISC_RD);
    hit_gfx_idx = (io_addr == P_GFX_IDX);
    hit_gfx_dat = (io_addr == P_GFX_DAT);
    hit_crt_idx = (io_addr == P_CRT_IDX);
    hit_crt_dat = (io_addr == P_CRT_DAT);
    hit_stat1   = (io_addr == P_STAT1);
  end

  attr_phase_e   attr_phase;
  logic          attr_port_wr;
  logic          stat1_rd;

  always_comb begin
    attr_port_wr = io_wr && hit_attr_wr;
    stat1_rd     = io_rd && hit_stat1;
  end

  vga_attr_phase i_phase (
    .clk     (clk),
    .rst_n   (rst_int_n),
    .port_wr (attr_port_wr),
    .clr     (stat1_rd),
    .phase_q (attr_phase)
  );

  logic [DW-1:0] attr_idx, attr_dat, seq_idx, seq_dat;
  logic [DW-1:0] gfx_idx, gfx_dat, crt_idx, crt_dat;

  vga_idx_bank #(.NUM_REGS(ATTR_REGS), .W(DW)) i_attr (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .idx_we (attr_port_wr && (attr_phase == PH_INDEX)),
    .dat_we (attr_port_wr && (attr_phase == PH_DATA)),
    .wdata  (io_wdata),
    .idx_q  (attr_idx),
    .dat_rd (attr_dat)
  );

  vga_idx_bank #(.NUM_REGS(SEQ_REGS), .W(DW)) i_seq (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .idx_we (io_wr && hit_seq_idx),
    .dat_we (io_wr && hit_seq_dat),
    .wdata  (io_wdata),
    .idx_q  (seq_idx),
    .dat_rd (seq_dat)
  );

  vga_idx_bank #(.NUM_REGS(GFX_REGS), .W(DW)) i_gfx (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .idx_we (io_wr && hit_gfx_idx),
    .dat_we (io_wr && hit_gfx_dat),
    .wdata  (io_wdata),
    .idx_q  (gfx_idx),
    .dat_rd (gfx_dat)
  );

  vga_idx_bank #(.NUM_REGS(CRT_REGS), .W(DW)) i_crt (
    .clk    (clk),
    .rst_n  (rst_int_n),
    .idx_we (io_wr && hit_crt_idx),
    .dat_we (io_wr && hit_crt_dat),
    .wdata  (io_wdata),
    .idx_q  (crt_idx),
    .dat_rd (crt_dat)
  );

  logic [DW-1:0] misc_q, feat_q, stat1;

  vga_ctrl_regs i_ctrl (
    .clk      (clk),
    .rst_n    (rst_int_n),
    .misc_we  (io_wr && hit_misc_wr),
    .feat_we  (io_wr && hit_stat1),
    .wdata    (io_wdata),
    .vretrace (vretrace),
    .disp_en  (disp_en),
    .misc_q   (misc_q),
    .feat_q   (feat_q),
    .stat1    (stat1)
  );

  // read mux and registered read data
  logic [DW-1:0] rdata_d;
  logic          rdata_en;

  always_comb begin
    rdata_en = io_rd;
    unique case (1'b1)
      hit_attr_wr: rdata_d = attr_idx;
      hit_attr_rd: rdata_d = attr_dat;
      hit_misc_wr: rdata_d = STAT0_VAL;
      hit_seq_idx: rdata_d = seq_idx;
      hit_seq_dat: rdata_d = seq_dat;
      hit_feat_rd: rdata_d = feat_q;
      hit_misc_rd: rdata_d = misc_q;
      hit_gfx_idx: rdata_d = gfx_idx;
      hit_gfx_dat: rdata_d = gfx_dat;
      hit_crt_idx: rdata_d = crt_idx;
      hit_crt_dat: rdata_d = crt_dat;
      hit_stat1:   rdata_d = stat1;
      default:     rdata_d = UNMAPPED_VAL;
    endcase
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n)    io_rdata <= '0;
    else if (rdata_en) io_rdata <= rdata_d;
  end
endmodule

// File: rtl/vga_port_regs_chk.sv
module vga_port_regs_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] io_addr,
  input logic        io_wr,
  input logic        io_rd,
  input logic [7:0]  io_rdata,
  input logic        vretrace,
  input logic        disp_en,
  input logic        attr_phase
);
  assert_rdata_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !io_rd |=> $stable(io_rdata));

  assert_phase_toggle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (io_wr && io_addr == 16'h03C0 && !io_rd) |=> (attr_phase != $past(attr_phase)));

  assert_phase_clear_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 16'h03DA) |=> !attr_phase);

  assert_stat1_format_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr == 16'h03DA) |=>
      (io_rdata == {4'b0000, $past(vretrace), 2'b00, ~$past(disp_en)}));

  assert_far_unmapped_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (io_rd && io_addr[15:10] != 6'd0) |=> (io_rdata == 8'hFF));
endmodule

bind vga_port_regs vga_port_regs_chk i_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .io_addr    (io_addr),
  .io_wr      (io_wr),
  .io_rd      (io_rd),
  .io_rdata   (io_rdata),
  .vretrace   (vretrace),
  .disp_en    (disp_en),
  .attr_phase (attr_phase)
);

// File: tb/test_vga_port_regs.sv
module test_vga_port_regs;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] io_addr = '0;
  logic        io_wr = 1'b0;
  logic        io_rd = 1'b0;
  logic [7:0]  io_wdata = '0;
  logic [7:0]  io_rdata;
  logic        vretrace = 1'b0;
  logic        disp_en = 1'b0;

  always #2 clk = ~clk;

  vga_port_regs i_vga_port_regs (
    .clk(clk), .rst_n(rst_n), .io_addr(io_addr), .io_wr(io_wr), .io_rd(io_rd),
    .io_wdata(io_wdata), .io_rdata(io_rdata), .vretrace(vretrace), .disp_en(disp_en)
  );

  // behavioural reference model
  int    m_seq[5], m_gfx[9], m_crt[25], m_attr[21];
  int    m_sidx, m_gidx, m_cidx, m_aidx, m_misc, m_feat;
  bit    m_data_phase;
  int    exp_rdata;
  string tag = "R1";
  bit    checking = 0;
  bit    done = 0;
  int    n_checks = 0, n_errors = 0;

  function automatic int model_read(input int a, input bit vr, input bit de);
    case (a)
      'h3C0: return m_aidx;
      'h3C1: return (m_aidx < 21) ? m_attr[m_aidx] : 'hFF;
      'h3C2: return 0;
      'h3C4: return m_sidx;
      'h3C5: return (m_sidx < 5) ? m_seq[m_sidx] : 'hFF;
      'h3CA: return m_feat;
      'h3CC: return m_misc;
      'h3CE: return m_gidx;
      'h3CF: return (m_gidx < 9) ? m_gfx[m_gidx] : 'hFF;
      'h3D4: return m_cidx;
      'h3D5: return (m_cidx < 25) ? m_crt[m_cidx] : 'hFF;
      'h3DA: return (vr ? 8 : 0) + (de ? 0 : 1);
      default: return 'hFF;
    endcase
  endfunction

  task automatic model_write(input int a, input int d);
    case (a)
      'h3C0: begin
        if (m_data_phase) begin if (m_aidx < 21) m_attr[m_aidx] = d; end
        else m_aidx = d;
        m_data_phase = !m_data_phase;
      end
      'h3C2: m_misc = d;
      'h3C4: m_sidx = d;
      'h3C5: if (m_sidx < 5) m_seq[m_sidx] = d;
      'h3CE: m_gidx = d;
      'h3CF: if (m_gidx < 9) m_gfx[m_gidx] = d;
      'h3D4: m_cidx = d;
      'h3D5: if (m_cidx < 25) m_crt[m_cidx] = d;
      'h3DA: m_feat = d;
      default: ;
    endcase
  endtask

  // compare on every clock, away from the active edge
  always @(negedge clk) begin
    if (checking) begin
      n_checks++;
      if (io_rdata !== exp_rdata[7:0]) begin
        n_errors++;
        $display("FAIL %s: io_rdata actual %02h expected %02h", tag, io_rdata, exp_rdata[7:0]);
      end
    end
  end

  task automatic op(input bit is_wr, input int a, input int d, input bit vr, input bit de,
                    input string req);
    @(negedge clk);
    io_addr = a[15:0]; io_wr = is_wr; io_rd = !is_wr; io_wdata = d[7:0];
    vretrace = vr; disp_en = de; tag = req;
    @(posedge clk);
    #1;
    if (is_wr) model_write(a, d);
    else begin
      exp_rdata = model_read(a, vr, de);
      if (a == 'h3DA) m_data_phase = 0;
    end
    io_wr = 0; io_rd = 0;
  endtask

  task automatic wr(input int a, input int d, input string req);
    op(1, a, d, 0, 1, req);
  endtask

  task automatic rd(input int a, input string req);
    op(0, a, 0, 0, 1, req);
  endtask

  task automatic idle(input int n, input string req);
    tag = req;
    repeat (n) @(negedge clk);
  endtask

  initial begin
    foreach (m_seq[i])  m_seq[i] = 0;
    foreach (m_gfx[i])  m_gfx[i] = 0;
    foreach (m_crt[i])  m_crt[i] = 0;
    foreach (m_attr[i]) m_attr[i] = 0;
    m_sidx = 0; m_gidx = 0; m_cidx = 0; m_aidx = 0; m_misc = 0; m_feat = 0;
    m_data_phase = 0; exp_rdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    checking = 1;

    // R1: reset values
    idle(2, "R1");
    rd('h3C4, "R1"); rd('h3C5, "R1"); rd('h3CE, "R1"); rd('h3D5, "R1");
    rd('h3C0, "R1"); rd('h3C1, "R1"); rd('h3CC, "R1"); rd('h3CA, "R1");

    // R3 / R6: sequencer sweep one past the end
    for (int i = 0; i < 6; i++) begin
      wr('h3C4, i, "R3"); wr('h3C5, 'h10 + i * 7, "R3");
    end
    for (int i = 0; i < 6; i++) begin
      wr('h3C4, i, "R3"); rd('h3C4, "R3"); rd('h3C5, (i < 5) ? "R3" : "R6");
    end

    // R4 / R6: graphics
    for (int i = 0; i < 10; i++) begin
      wr('h3CE, i, "R4"); wr('h3CF, 'hA0 ^ (i * 3), "R4");
    end
    for (int i = 0; i < 10; i++) begin
      wr('h3CE, i, "R4"); rd('h3CF, (i < 9) ? "R4" : "R6");
    end
    rd('h3CE, "R4");

    // R5 / R6: CRT sweep
    for (int i = 0; i < 26; i++) begin
      wr('h3D4, i, "R5"); wr('h3D5, (i * 9 + 1) & 'hFF, "R5");
    end
    for (int i = 0; i < 26; i++) begin
      wr('h3D4, i, "R5"); rd('h3D5, (i < 25) ? "R5" : "R6");
    end
    wr('h3D4, 'hC8, "R6"); wr('h3D5, 'h55, "R6"); rd('h3D5, "R6"); rd('h3D4, "R5");

    // R2: hold between reads
    rd('h3C4, "R2"); idle(5, "R2");

    // R7 / R8: attribute alternation
    rd('h3DA, "R8");
    wr('h3C0, 3, "R7"); wr('h3C0, 'h5A, "R7");
    wr('h3C0, 20, "R7"); wr('h3C0, 'hA5, "R7");
    rd('h3C0, "R7"); rd('h3C1, "R7");
    wr('h3C0, 3, "R7"); rd('h3C1, "R7");
    wr('h3C0, 'h66, "R7");               // data phase after the index above
    wr('h3C0, 21, "R6"); wr('h3C0, 'h77, "R6"); rd('h3C1, "R6");
    // half-way pair interrupted by a status read
    wr('h3C0, 2, "R8");
    rd('h3DA, "R8");
    wr('h3C0, 4, "R8"); wr('h3C0, 'h99, "R8");
    rd('h3C0, "R8"); rd('h3C1, "R8");
    wr('h3C0, 2, "R8"); rd('h3C1, "R8");
    rd('h3DA, "R8");

    // R9: status bit combinations
    for (int v = 0; v < 4; v++) op(0, 'h3DA, 0, v[1], v[0], "R9");

    // R10 / R11
    wr('h3C2, 'hE3, "R10"); rd('h3CC, "R10"); rd('h3C2, "R10");
    wr('h3DA, 'h0B, "R11"); rd('h3CA, "R11"); rd('h3CC, "R10");

    // R12: unmapped reads and writes
    wr('h3C3, 'h12, "R12"); wr('h3CB, 'h34, "R12"); wr('h1234, 'h56, "R12");
    rd('h3C3, "R12"); rd('h03B4, "R12"); rd('hFFFF, "R12"); rd('h0000, "R12");
    rd('h3CC, "R12"); rd('h3CA, "R12"); rd('h3C4, "R12");
    idle(3, "R2");

    checking = 0;
    done = 1;
    $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("CHECKS %0d ERRORS %0d", n_checks, n_errors);
      $finish;
    end
  end
endmodule